// File: doc/BRIEF.md
# FM / MFM Serial Line Encoder

This block turns a stream of parallel bytes into a one-bit level waveform for a recording or transmission medium. It uses either frequency modulation (FM) or modified FM (MFM). Each data bit fills one bit cell, and each cell is split into two half-cell slots. An external clock divider paces the slots through a single-cycle strobe. On every transition the encoder inverts its output level, so the information is carried by the positions of the flips and not by the level itself.

Bytes arrive over a valid/ready handshake and are sent most significant bit first. A new byte is taken in the slot that closes the last cell of the current byte, so bytes sent back to back leave no gap between them. When no byte is offered at that point, the encoder sends a byte of zeros. In FM this gives a steady clock-only pattern. The line code is picked by a mode input, and the encoder takes in that input only at byte boundaries. A byte is therefore never coded in a mix of the two schemes.

Top module: `flux_encoder`

## Requirements
- R1: During reset and on the first cycle after it, `lineOut` is 0 and `inReady` is 0.
- R2: `lineOut` changes only on a clock edge where `halfTick` is 1. Each bit cell takes exactly two ticks: the first is the boundary slot and the second is the mid-cell slot.
- R3: In FM mode (`modeMfm` latched as 0), `lineOut` inverts on every boundary slot.
- R4: In FM mode, `lineOut` inverts on the mid-cell slot when the cell's bit is 1 and holds when it is 0.
- R5: In MFM mode (`modeMfm` latched as 1), `lineOut` inverts on the mid-cell slot when the cell's bit is 1 and holds when it is 0.
- R6: In MFM mode, `lineOut` inverts on a boundary slot only when the previous cell's bit and the current cell's bit are both 0. The previous-bit memory resets to 1.
- R7: Bits leave MSB first. `inReady` is 1, combinationally, exactly when `halfTick` is 1 in the mid-cell slot of the last bit of a byte. The byte on `inData` is taken on that edge if `inValid` is 1.
- R8: With `inValid` held at 1, consecutive bytes follow each other cell after cell, with no idle cells between them.
- R9: A byte boundary with `inValid` at 0 loads an all-zero byte. In FM, such a byte produces exactly 8 flips over its 16 slots.
- R10: `modeMfm` is latched only on the edge that loads a byte, and it applies to that whole byte. Changes at any other time have no effect.
- R11: After reset the encoder is in the last cell of an idle zero byte with FM latched. Its first tick therefore drives `lineOut` to 1, and the first byte is taken at the end of that cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| halfTick | input | 1 | Half-cell strobe from the divider |
| modeMfm | input | 1 | Line code select: 0 = FM, 1 = MFM |
| inData | input | 8 | Byte to send, MSB first |
| inValid | input | 1 | `inData` holds a byte |
| inReady | output | 1 | Byte is taken on this edge |
| lineOut | output | 1 | Encoded line level |

## Verification
The encoder is driven with idle zero streams in both codes. In FM these give the bare clock pattern, and in MFM they exercise the rule that a boundary flips only between two zeros. Saturated back-to-back traffic separates a gapless handoff from one that inserts a cell. A long random phase mixes valid gaps, irregular spacing of the strobe and a mode input that changes in the middle of a byte. That phase exposes a mode latched at the wrong time, a wrong bit order and a wrong boundary rule around 1-to-0 and 0-to-0 pairs. The first tick after reset confirms the reset state of the previous bit and of the mode.

// File: rtl/flux_enc_pkg.sv
package flux_enc_pkg;
  typedef struct packed {
    logic edgeSlot;   // boundary half of a cell
    logic midSlot;    // middle half of a cell
    logic loadByte;   // last mid slot of a byte: fetch next
    logic mfm;        // latched line code
  } encStrobe_t;
endpackage

// File: rtl/flux_enc_ctrl.sv
module flux_enc_ctrl
  import flux_enc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       halfTick,
  input  logic       modeMfm,
  output encStrobe_t strb,
  output logic       inReady
);
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

  logic             phaseMid;
  logic [CNT_W-1:0] bitCnt;
  logic             modeReg;
  logic             lastCell;

  assign lastCell      = (bitCnt == LAST_IDX);
  assign strb.edgeSlot = halfTick & ~phaseMid;
  assign strb.midSlot  = halfTick & phaseMid;
  assign strb.loadByte = halfTick & phaseMid & lastCell;
  assign strb.mfm      = modeReg;
  assign inReady       = strb.loadByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseMid <= 1'b0;
      bitCnt   <= LAST_IDX;
      modeReg  <= 1'b0;
    end else if (halfTick) begin
      phaseMid <= ~phaseMid;
      if (phaseMid) begin
        if (lastCell) begin
          bitCnt  <= '0;
          modeReg <= modeMfm;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halfTick && !phaseMid) |=> $stable(bitCnt));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadByte |=> $stable(modeReg));
endmodule

// File: rtl/flux_enc_datapath.sv
module flux_enc_datapath
  import flux_enc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  encStrobe_t        strb,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  output logic              lineOut
);
  logic [BYTE_W-1:0] shiftReg;
  logic              prevBit;
  logic              curBit;
  logic              edgeFlip;
  logic              flip;
  logic              midFlipped;

  assign curBit   = shiftReg[BYTE_W-1];
  assign edgeFlip = strb.mfm ? (~prevBit & ~curBit) : 1'b1;
  assign flip     = (strb.edgeSlot & edgeFlip) | (strb.midSlot & curBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg   <= '0;
      prevBit    <= 1'b1;
      lineOut    <= 1'b0;
      midFlipped <= 1'b0;
    end else begin
      if (flip) lineOut <= ~lineOut;
      if (strb.midSlot) begin
        prevBit    <= curBit;
        midFlipped <= curBit;
        if (strb.loadByte) shiftReg <= inValid ? inData : '0;
        else               shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
      end else if (strb.edgeSlot) begin
        midFlipped <= 1'b0;
      end
    end
  end

  // R3
  fm_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.edgeSlot && !strb.mfm) |=> (lineOut != $past(lineOut)));

  // R6
  mfm_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.edgeSlot && strb.mfm && midFlipped) |=> $stable(lineOut));

  // R7
  msb_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.midSlot && !strb.loadByte) |=>
      (shiftReg == {$past(shiftReg[BYTE_W-2:0]), 1'b0}));
endmodule

// File: rtl/flux_encoder.sv
module flux_encoder
  import flux_enc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfTick,
  input  logic              modeMfm,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              lineOut
);
  encStrobe_t strb;

  flux_enc_ctrl #(.BYTE_W(BYTE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .halfTick(halfTick), .modeMfm(modeMfm),
    .strb(strb), .inReady(inReady)
  );

  flux_enc_datapath #(.BYTE_W(BYTE_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .inValid(inValid), .lineOut(lineOut)
  );

  // R2
  line_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !halfTick |=> $stable(lineOut));
endmodule

// File: tb/flux_encoder_test.sv
module flux_encoder_test;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          halfTick = 1'b0;
  logic          modeMfm = 1'b0;
  logic [BW-1:0] inData = '0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic          lineOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // reference state, derived from the requirements
  logic [BW-1:0] mByte;
  int            mIdx;
  bit            mPhase;
  bit            mPrev;
  bit            mMode;
  bit            mLevel;
  bit            firstTick;
  int            byteFlips;
  bit            lastSeen;

  flux_encoder #(.BYTE_W(BW)) uut (
    .clk(clk), .rstN(rstN), .halfTick(halfTick), .modeMfm(modeMfm),
    .inData(inData), .inValid(inValid), .inReady(inReady), .lineOut(lineOut)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit refBit(input logic [BW-1:0] b, input int idx);
    return b[BW-1-idx];
  endfunction

  task automatic modelReset();
    mByte = '0; mIdx = BW - 1; mPhase = 1'b0; mPrev = 1'b1;
    mMode = 1'b0; mLevel = 1'b0; firstTick = 1'b1; byteFlips = 0; lastSeen = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; halfTick = 1'b0; inValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelReset();
    #1;
    chk(lineOut == 1'b0, "R1", lineOut, 0);
    chk(inReady == 1'b0, "R1", inReady, 0);
  endtask

  task automatic run(input int ticks, input int vPct, input int mPct,
                     input int gapMax, input bit idleCheck);
    for (int t = 0; t < ticks; t++) begin
      int gap;
      gap = (gapMax == 0) ? 0 : int'($urandom % (gapMax + 1));
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        halfTick = 1'b0;
        modeMfm = ($urandom % 100) < mPct;
        @(posedge clk); #1;
        chk(lineOut == mLevel, "R2", lineOut, mLevel);
      end
      begin
        bit expReady, cur, flip, wasEdge, doneMode;
        logic [BW-1:0] doneByte;
        string tag;
        @(negedge clk);
        halfTick = 1'b1;
        inValid  = ($urandom % 100) < vPct;
        inData   = BW'($urandom);
        modeMfm  = ($urandom % 100) < mPct;
        #1;
        expReady = mPhase && (mIdx == BW - 1);
        chk(inReady == expReady, inValid ? "R8" : "R7", inReady, expReady);
        @(posedge clk); #1;
        cur = refBit(mByte, mIdx);
        wasEdge = !mPhase;
        doneMode = mMode; doneByte = mByte;
        if (wasEdge) begin
          flip = mMode ? (!mPrev && !cur) : 1'b1;
          tag = mMode ? "R6" : "R3";
          if (mIdx == 0 && modeMfm != mMode) tag = "R10";
          if (firstTick) tag = "R11";
          mPhase = 1'b1;
        end else begin
          flip = cur;
          tag = mMode ? "R5" : "R4";
          mPrev = cur;
          mPhase = 1'b0;
        end
        if (flip) mLevel = !mLevel;
        chk(lineOut == mLevel, tag, lineOut, mLevel);
        if (lineOut != lastSeen) byteFlips++;
        lastSeen = lineOut;
        firstTick = 1'b0;
        if (!wasEdge) begin
          if (mIdx == BW - 1) begin
            if (idleCheck && !doneMode && doneByte == '0)
              chk(byteFlips == 2 * BW / 2, "R9", byteFlips, BW);
            byteFlips = 0;
            mIdx = 0;
            mByte = inValid ? inData : '0;
            mMode = modeMfm;
          end else begin
            mIdx++;
          end
        end
      end
    end
    @(negedge clk);
    halfTick = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    doReset();
    run(2, 0, 0, 0, 0);           // reset cell: first tick, R11
    run(48, 0, 0, 0, 1);          // idle FM clock pattern, R9
    run(64, 100, 0, 0, 0);        // back-to-back FM, R8
    run(64, 100, 100, 1, 0);      // back-to-back MFM, R5 R6
    run(64, 0, 100, 2, 0);        // idle MFM zeros
    doReset();
    run(1600, 70, 50, 3, 0);      // random mix with mode changing mid-byte, R10
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule